// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Accumulator

This block keeps a 16-bit checksum that absorbs one 4-bit nibble per clock whenever the nibble strobe is raised. Each step shifts the register right by one nibble and XORs in a product: the low nibble of (register XOR incoming nibble) multiplied by 0x1081. The strobe is driven by whatever logic decides which memory reads are checksummed. That choice sits outside this block. A read that must contribute zero, such as one that lands in a disabled register window, is presented as a strobe carrying 0x0.

Software sees the same register as four nibble-wide locations on a small register bus. Through these locations it can seed the checksum one nibble at a time and read it back. A read is a pure combinational selection and never changes the register. If a bus write and a strobe arrive in the same cycle, the write wins and the strobe is dropped.

Top module: `crc_nibble_acc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the register reads 0x0000.
- R2: A strobe with nibble n and no bus write in a cycle sets the register to (crc >> 4) XOR (((crc XOR n) & 0xF) * 0x1081), kept to 16 bits. The new value appears one clock edge later. For example, 0x0000 with n = 0x1 gives 0x1081.
- R3: In a cycle with neither a strobe nor a bus write, the register keeps its value.
- R4: A bus write with index k (0..3) puts the write data into bits 4k+3:4k and leaves the other twelve bits unchanged. Index 0 is the least significant nibble.
- R5: The read nibble always equals bits 4k+3:4k of the current register, where k is the bus index, in the same cycle, and selecting an index does not alter the register.
- R6: When a bus write and a strobe occur in the same cycle, only the write takes effect.
- R7: A strobe carrying 0x0 is folded in like any other nibble. From 0x0000 the register stays 0x0000. From 0x0001 it becomes 0x1081.
- R8: Over a long random mix of strobes, writes, collisions and idle cycles, the register follows the update rules above exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_vld | input | 1 | Strobe: fold nib_data into the checksum |
| nib_data | input | 4 | Nibble to fold in |
| reg_sel | input | 2 | Register-bus nibble index |
| reg_we | input | 1 | Register-bus write enable |
| reg_wdata | input | 4 | Register-bus write data |
| crc_value | output | 16 | Current checksum |
| reg_rdata | output | 4 | Selected checksum nibble |

## Verification
The register updates on the clock edge that samples the strobe or the write, so crc_value is due one edge after the stimulus. The bench drives inputs on the falling edge, advances its own model at the rising edge, and compares on the following falling edge. reg_rdata depends only on the index and the stored value, so it is compared in the same cycle, shortly after the index changes and before the next rising edge. Collision cycles and zero-nibble strobes are checked against fixed constants as well as against the model.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;
  localparam int unsigned DEF_NIB_W = 4;
  localparam int unsigned DEF_NIBS  = 4;
  localparam int unsigned DEF_MULT  = 'h1081;

  typedef enum logic [1:0] {
    LANE_HOLD = 2'd0,
    LANE_LOAD = 2'd1,
    LANE_STEP = 2'd2
  } lane_act_e;
endpackage

// File: rtl/crc_step_unit.sv
module crc_step_unit
  import crc_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS,
  parameter int unsigned MULT  = DEF_MULT,
  localparam int unsigned CRC_W = NIB_W * NIBS
) (
  input  logic [CRC_W-1:0] cur,
  input  logic [NIB_W-1:0] nib,
  output logic [CRC_W-1:0] nxt
);
  localparam logic [CRC_W-1:0] MULT_V = CRC_W'(MULT);

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                            input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] low;
    logic [CRC_W-1:0] prod;
    low  = c[NIB_W-1:0] ^ n;
    prod = CRC_W'(low) * MULT_V;
    return (c >> NIB_W) ^ prod;
  endfunction

  always_comb nxt = fold(cur, nib);
endmodule

// File: rtl/crc_lane_bank.sv
module crc_lane_bank
  import crc_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS,
  localparam int unsigned CRC_W = NIB_W * NIBS,
  localparam int unsigned SEL_W = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_take,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NIB_W-1:0] wr_data,
  input  logic [CRC_W-1:0] step_val,
  output logic [CRC_W-1:0] state
);
  for (genvar k = 0; k < NIBS; k++) begin : g_lane
    lane_act_e        act;
    logic             wr_hit;
    logic [NIB_W-1:0] lane_q;

    assign wr_hit = wr_en && (wr_sel == SEL_W'(k));

    always_comb begin
      if (wr_en)          act = wr_hit ? LANE_LOAD : LANE_HOLD;
      else if (step_take) act = LANE_STEP;
      else                act = LANE_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else begin
        unique case (act)
          LANE_LOAD: lane_q <= wr_data;
          LANE_STEP: lane_q <= step_val[k*NIB_W +: NIB_W];
          default:   lane_q <= lane_q;
        endcase
      end
    end

    assign state[k*NIB_W +: NIB_W] = lane_q;
  end
endmodule

// File: rtl/crc_read_mux.sv
module crc_read_mux
  import crc_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS,
  localparam int unsigned CRC_W = NIB_W * NIBS,
  localparam int unsigned SEL_W = $clog2(NIBS)
) (
  input  logic [CRC_W-1:0] state,
  input  logic [SEL_W-1:0] sel,
  output logic [NIB_W-1:0] rdata
);
  logic [NIB_W-1:0] lanes [NIBS];

  for (genvar k = 0; k < NIBS; k++) begin : g_tap
    assign lanes[k] = state[k*NIB_W +: NIB_W];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NIBS; k++)
      if (sel == SEL_W'(k)) rdata = lanes[k];
  end
endmodule

// File: rtl/crc_nibble_acc.sv
module crc_nibble_acc
  import crc_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS,
  parameter int unsigned MULT  = DEF_MULT,
  localparam int unsigned CRC_W = NIB_W * NIBS,
  localparam int unsigned SEL_W = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_vld,
  input  logic [NIB_W-1:0] nib_data,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_we,
  input  logic [NIB_W-1:0] reg_wdata,
  output logic [CRC_W-1:0] crc_value,
  output logic [NIB_W-1:0] reg_rdata
);
  logic [CRC_W-1:0] state;
  logic [CRC_W-1:0] step_val;
  logic             step_take;

  assign step_take = nib_vld && !reg_we;

  crc_step_unit #(.NIB_W(NIB_W), .NIBS(NIBS), .MULT(MULT)) u_step (
    .cur (state),
    .nib (nib_data),
    .nxt (step_val)
  );

  crc_lane_bank #(.NIB_W(NIB_W), .NIBS(NIBS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_take (step_take),
    .wr_en     (reg_we),
    .wr_sel    (reg_sel),
    .wr_data   (reg_wdata),
    .step_val  (step_val),
    .state     (state)
  );

  crc_read_mux #(.NIB_W(NIB_W), .NIBS(NIBS)) u_rd (
    .state (state),
    .sel   (reg_sel),
    .rdata (reg_rdata)
  );

  assign crc_value = state;
endmodule

// File: rtl/crc_nibble_acc_chk.sv
module crc_nibble_acc_chk #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIBS  = 4,
  parameter int unsigned MULT  = 'h1081,
  localparam int unsigned CRC_W = NIB_W * NIBS,
  localparam int unsigned SEL_W = $clog2(NIBS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nib_vld,
  input logic [NIB_W-1:0] nib_data,
  input logic [SEL_W-1:0] reg_sel,
  input logic             reg_we,
  input logic [NIB_W-1:0] reg_wdata,
  input logic [CRC_W-1:0] crc_value,
  input logic [NIB_W-1:0] reg_rdata,
  input logic             step_take
);
  localparam logic [CRC_W-1:0] NMASK = CRC_W'((1 << NIB_W) - 1);

  // Product written as a shift-and-add sum over the multiplier's set bits.
  function automatic logic [CRC_W-1:0] expect_fold(input logic [CRC_W-1:0] c,
                                                   input logic [NIB_W-1:0] n);
    logic [CRC_W-1:0] t, acc;
    t   = (c ^ CRC_W'(n)) & NMASK;
    acc = '0;
    for (int b = 0; b < CRC_W; b++)
      if (((MULT >> b) & 1) != 0) acc = acc + (t << b);
    return (c >> NIB_W) ^ acc;
  endfunction

  function automatic logic [CRC_W-1:0] lane_mask(input logic [SEL_W-1:0] s);
    return NMASK << (NIB_W * s);
  endfunction

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> crc_value == '0); // R1

  AST_STEP_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && !reg_we) |=> crc_value == expect_fold($past(crc_value), $past(nib_data))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_vld && !reg_we) |=> $stable(crc_value)); // R3

  AST_WRITE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (crc_value & lane_mask($past(reg_sel))) ==
               (CRC_W'($past(reg_wdata)) << (NIB_W * $past(reg_sel)))); // R4

  AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ((crc_value ^ $past(crc_value)) & ~lane_mask($past(reg_sel))) == '0); // R6

  AST_READ_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    CRC_W'(reg_rdata) == ((crc_value >> (NIB_W * reg_sel)) & NMASK)); // R5

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && reg_we) |-> !step_take); // R6
endmodule

bind crc_nibble_acc crc_nibble_acc_chk #(.NIB_W(NIB_W), .NIBS(NIBS), .MULT(MULT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nib_vld   (nib_vld),
  .nib_data  (nib_data),
  .reg_sel   (reg_sel),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .crc_value (crc_value),
  .reg_rdata (reg_rdata),
  .step_take (step_take)
);

// File: tb/tb_crc_nibble_acc.sv
`timescale 1ns/1ps
module tb_crc_nibble_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nib_vld = 1'b0;
  logic [3:0]  nib_data = '0;
  logic [1:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_wdata = '0;
  logic [15:0] crc_value;
  logic [3:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  int model = 0;

  always #10 clk = ~clk;

  crc_nibble_acc dut (
    .clk(clk), .rst_n(rst_n), .nib_vld(nib_vld), .nib_data(nib_data),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .crc_value(crc_value), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, advance the model at the rising
  // edge, compare the register at the next falling edge.
  task automatic cycle(input bit v, input int d, input bit w, input int s,
                       input int wd, input string tag);
    nib_vld = v; nib_data = 4'(d); reg_we = w; reg_sel = 2'(s); reg_wdata = 4'(wd);
    #1;
    check("R5 read nibble", int'(reg_rdata), (model >> (4 * s)) & 15);
    @(posedge clk);
    if (w) begin
      model = (model & ~(15 << (4 * s))) | ((wd & 15) << (4 * s));
    end else if (v) begin
      int low;
      low = (model ^ d) & 15;
      model = ((model >> 4) ^ (low * 4225)) & 16'hFFFF;
    end
    @(negedge clk);
    check(tag, int'(crc_value), model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(crc_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(crc_value), 0);
    check("R1 read nibble", int'(reg_rdata), 0);

    cycle(1, 0, 0, 0, 0, "R7 zero nibble from zero");
    check("R7 literal", int'(crc_value), 16'h0000);
    cycle(1, 1, 0, 0, 0, "R2 single step");
    check("R2 literal", int'(crc_value), 16'h1081);
    cycle(0, 0, 1, 0, 1, "R4 write lane 0");
    cycle(0, 0, 1, 1, 0, "R4 write lane 1");
    cycle(0, 0, 1, 2, 0, "R4 write lane 2");
    cycle(0, 0, 1, 3, 0, "R4 write lane 3");
    check("R4 seed literal", int'(crc_value), 16'h0001);
    cycle(1, 0, 0, 2, 0, "R7 zero nibble from one");
    check("R7 literal", int'(crc_value), 16'h1081);
    cycle(0, 0, 1, 2, 10, "R4 write lane 2 only");
    check("R4 literal", int'(crc_value), 16'h1A81);
    cycle(1, 7, 1, 3, 5, "R6 write beats strobe");
    check("R6 literal", int'(crc_value), 16'h5A81);
    for (int i = 0; i < 4; i++) cycle(0, 9, 0, i, 3, "R3 idle hold");
    check("R3 literal", int'(crc_value), 16'h5A81);

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: cycle(0, int'($urandom % 16), 0, int'($urandom % 4), int'($urandom % 16), "R8 random idle");
        1: cycle(1, int'($urandom % 16), 0, int'($urandom % 4), int'($urandom % 16), "R8 random step");
        2: cycle(0, int'($urandom % 16), 1, int'($urandom % 4), int'($urandom % 16), "R8 random write");
        default: cycle(1, int'($urandom % 16), 1, int'($urandom % 4), int'($urandom % 16), "R8 random collide");
      endcase
    end

    nib_vld = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule